// File: doc/BRIEF.md
# Four-Slot Time-Division Memory Arbiter

This block shares one main memory among four channels by cutting time into fixed slots. It runs from a 40 MHz base clock, so each base cycle is one 25 ns slot, and four slots make a 100 ns frame. Every channel holds one processor and one copy engine. In its own slot a channel's processor gets the memory when its address falls in the main-memory range. When the processor is idle or addressing its private region, the channel's copy engine may take the slot instead.

The arbiter also generates four 10 MHz processor clocks. Each clock lags the previous channel's clock by one slot. Memory-side outputs are registered. The requests sampled at the edge that opens a slot decide everything driven during that slot, so grants and bus values never change inside a slot.

Top module: `tdm_mem_arbiter`

## Requirements
- R1: After reset is released, the slots are served in the order 0, 1, 2, 3, and then the order repeats. `activeCh` shows the channel being served. The first slot after release serves channel 0.
- R2: The processor of the served channel wins the slot when `cpuReq` is high and its address is at or above `MAIN_BASE` (default 16'h2000). The boundary value itself counts as main memory. During that slot `memEn` is 1, and `memAddr`, `memWData` and `memWe` carry that processor's address, data and write enable. This holds even when the copy engine is also requesting.
- R3: The copy engine of the served channel wins the slot when its `cpyReq` is high and the processor does not win. The memory outputs then carry the copy engine's address, data and write enable.
- R4: A slot that neither requester takes is idle. `memEn`, `memWe`, `memAddr` and `memWData` are all 0, and no grant is high.
- R5: `grantCpu` and `grantCpy` (bit n belongs to channel n) have at most one bit set between them. Any set bit is the bit of `activeCh`.
- R6: Requests, addresses, data and write enables of channels other than the served one have no effect on the memory outputs or the grants.
- R7: The outputs for a slot are decided by the inputs sampled at the base-clock edge that starts the slot. They stay constant for the whole slot.
- R8: `cpuClk[n]` is high during the slot of channel n and the slot after it, and low during the other two slots. This gives each channel a 10 MHz clock shifted by one slot from channel n-1.
- R9: While `rstN` is low, `activeCh` is 0 and every grant, `memEn`, `memWe` and every `cpuClk` bit is 0, whatever the requests are.
- R10: A processor request whose address is below `MAIN_BASE` (for example `MAIN_BASE`-1) does not take the slot. The copy engine can use the slot instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz base clock; one period is one slot |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | NUM_CH | Per-channel processor bus-cycle request |
| cpuAddr | input | NUM_CH*ADDR_W | Processor addresses, channel n in slice n |
| cpuWData | input | NUM_CH*DATA_W | Processor write data |
| cpuWe | input | NUM_CH | Processor write enables |
| cpyReq | input | NUM_CH | Copy engine requests |
| cpyAddr | input | NUM_CH*ADDR_W | Copy engine addresses |
| cpyWData | input | NUM_CH*DATA_W | Copy engine write data |
| cpyWe | input | NUM_CH | Copy engine write enables |
| cpuClk | output | NUM_CH | Phase-shifted processor clocks |
| activeCh | output | CH_W | Channel served in the current slot |
| grantCpu | output | NUM_CH | One-hot processor grant |
| grantCpy | output | NUM_CH | One-hot copy engine grant |
| memEn | output | 1 | Memory access valid in this slot |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory address |
| memWData | output | DATA_W | Memory write data |

## Verification
The bench aims at the address boundary on either side of `MAIN_BASE`. A decoder off by one there would hand a slot to the wrong requester, or would let a private access reach the memory. It drives both requesters of a channel at once to catch inverted priority. It fills idle slots to catch a bus that keeps stale values or a write enable left high. It drives busy random traffic on the other channels so that a wrong slice select shows up as foreign data on the bus. The processor clock check in every cycle catches a wrong phase or a wrong duty cycle, and the reset checks catch clocks or grants that start in an unknown state.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

  // Strobes from control to datapath for the slot being opened
  typedef struct packed {
    logic useCpu;
    logic useCpy;
  } arbStrobe_t;

endpackage

// File: rtl/tdm_arb_ctrl.sv
module tdm_arb_ctrl
  import tdm_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 16'h2000,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        cpuReq,
  input  logic [NUM_CH*ADDR_W-1:0] cpuAddr,
  input  logic [NUM_CH-1:0]        cpyReq,
  output logic [CH_W-1:0]          slotSel,
  output arbStrobe_t               strobe,
  output logic [NUM_CH-1:0]        cpuClk,
  output logic [CH_W-1:0]          activeCh,
  output logic [NUM_CH-1:0]        grantCpu,
  output logic [NUM_CH-1:0]        grantCpy
);

  localparam logic [CH_W:0] HALF_V = (CH_W+1)'(NUM_CH / 2);

  logic [CH_W-1:0]   slotCnt;
  logic [ADDR_W-1:0] selAddr;
  logic              cpuMain;
  logic [NUM_CH-1:0] chBit;
  logic              startedQ;

  assign slotSel = slotCnt;
  assign chBit   = NUM_CH'(1) << slotCnt;

  // Decode for the channel whose slot opens at the next edge
  always_comb begin
    selAddr       = cpuAddr[slotCnt*ADDR_W +: ADDR_W];
    cpuMain       = cpuReq[slotCnt] && (selAddr >= MAIN_BASE);
    strobe.useCpu = cpuMain;
    strobe.useCpy = !cpuMain && cpyReq[slotCnt];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt  <= '0;
      activeCh <= '0;
      grantCpu <= '0;
      grantCpy <= '0;
      startedQ <= 1'b0;
    end else begin
      slotCnt  <= slotCnt + CH_W'(1);
      activeCh <= slotCnt;
      grantCpu <= strobe.useCpu ? chBit : '0;
      grantCpy <= strobe.useCpy ? chBit : '0;
      startedQ <= 1'b1;
    end
  end

  // Clock n is high for the slot of channel n and the one after it
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clk
    logic [CH_W-1:0] phase;
    assign phase = slotCnt - CH_W'(ch);
    always_ff @(posedge clk) begin
      if (!rstN) cpuClk[ch] <= 1'b0;
      else       cpuClk[ch] <= ({1'b0, phase} < HALF_V);
    end
  end

  a_r1_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    startedQ |=> (activeCh == $past(activeCh) + CH_W'(1)));

  a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantCpu | grantCpy) && ((grantCpu & grantCpy) == '0));

  a_r5_grant_active: assert property (@(posedge clk) disable iff (!rstN)
    (|(grantCpu | grantCpy)) |-> ((grantCpu | grantCpy) == (NUM_CH'(1) << activeCh)));

  a_r8_clk_duty: assert property (@(posedge clk) disable iff (!rstN)
    startedQ |-> ($countones(cpuClk) == NUM_CH / 2));

  a_r8_clk_own_slot: assert property (@(posedge clk) disable iff (!rstN)
    startedQ |-> cpuClk[activeCh]);

endmodule

// File: rtl/tdm_arb_datapath.sv
module tdm_arb_datapath
  import tdm_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  arbStrobe_t               strobe,
  input  logic [CH_W-1:0]          slotSel,
  input  logic [NUM_CH*ADDR_W-1:0] cpuAddr,
  input  logic [NUM_CH*DATA_W-1:0] cpuWData,
  input  logic [NUM_CH-1:0]        cpuWe,
  input  logic [NUM_CH*ADDR_W-1:0] cpyAddr,
  input  logic [NUM_CH*DATA_W-1:0] cpyWData,
  input  logic [NUM_CH-1:0]        cpyWe,
  output logic                     memEn,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWData
);

  logic [ADDR_W-1:0] nxtAddr;
  logic [DATA_W-1:0] nxtData;
  logic              nxtWe;

  always_comb begin
    nxtAddr = '0;
    nxtData = '0;
    nxtWe   = 1'b0;
    if (strobe.useCpu) begin
      nxtAddr = cpuAddr[slotSel*ADDR_W +: ADDR_W];
      nxtData = cpuWData[slotSel*DATA_W +: DATA_W];
      nxtWe   = cpuWe[slotSel];
    end else if (strobe.useCpy) begin
      nxtAddr = cpyAddr[slotSel*ADDR_W +: ADDR_W];
      nxtData = cpyWData[slotSel*DATA_W +: DATA_W];
      nxtWe   = cpyWe[slotSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memEn    <= 1'b0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memWData <= '0;
    end else begin
      memEn    <= strobe.useCpu | strobe.useCpy;
      memWe    <= nxtWe;
      memAddr  <= nxtAddr;
      memWData <= nxtData;
    end
  end

  a_r4_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    !memEn |-> (!memWe && memAddr == '0 && memWData == '0));

endmodule

// File: rtl/tdm_mem_arbiter.sv
module tdm_mem_arbiter
  import tdm_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 16'h2000,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        cpuReq,
  input  logic [NUM_CH*ADDR_W-1:0] cpuAddr,
  input  logic [NUM_CH*DATA_W-1:0] cpuWData,
  input  logic [NUM_CH-1:0]        cpuWe,
  input  logic [NUM_CH-1:0]        cpyReq,
  input  logic [NUM_CH*ADDR_W-1:0] cpyAddr,
  input  logic [NUM_CH*DATA_W-1:0] cpyWData,
  input  logic [NUM_CH-1:0]        cpyWe,
  output logic [NUM_CH-1:0]        cpuClk,
  output logic [CH_W-1:0]          activeCh,
  output logic [NUM_CH-1:0]        grantCpu,
  output logic [NUM_CH-1:0]        grantCpy,
  output logic                     memEn,
  output logic                     memWe,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWData
);

  arbStrobe_t      strobe;
  logic [CH_W-1:0] slotSel;

  tdm_arb_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr),
    .cpyReq(cpyReq), .slotSel(slotSel), .strobe(strobe),
    .cpuClk(cpuClk), .activeCh(activeCh),
    .grantCpu(grantCpu), .grantCpy(grantCpy)
  );

  tdm_arb_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotSel(slotSel),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData), .cpuWe(cpuWe),
    .cpyAddr(cpyAddr), .cpyWData(cpyWData), .cpyWe(cpyWe),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWData(memWData)
  );

  // R2/R3: a grant and a live bus go together
  a_r2_en_has_grant: assert property (@(posedge clk) disable iff (!rstN)
    memEn == (|(grantCpu | grantCpy)));

endmodule

// File: tb/sim_tdm_mem_arbiter.sv
module sim_tdm_mem_arbiter;

  localparam int NUM_CH = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CH_W   = 2;
  localparam logic [ADDR_W-1:0] MAIN_BASE = 16'h2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0]        cpuReq = '0, cpuWe = '0, cpyReq = '0, cpyWe = '0;
  logic [NUM_CH*ADDR_W-1:0] cpuAddr = '0, cpyAddr = '0;
  logic [NUM_CH*DATA_W-1:0] cpuWData = '0, cpyWData = '0;
  logic [NUM_CH-1:0]        cpuClk, grantCpu, grantCpy;
  logic [CH_W-1:0]          activeCh;
  logic                     memEn, memWe;
  logic [ADDR_W-1:0]        memAddr;
  logic [DATA_W-1:0]        memWData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values for the slot about to open
  int                expCh;
  logic              expEn, expWe;
  logic [ADDR_W-1:0] expAddr;
  logic [DATA_W-1:0] expData;
  logic [NUM_CH-1:0] expGC, expGY, expClk;
  int                benchSlot = 0;

  always #2 clk = ~clk;

  tdm_mem_arbiter #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_BASE(MAIN_BASE)
  ) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuWe(cpuWe), .cpyReq(cpyReq), .cpyAddr(cpyAddr),
    .cpyWData(cpyWData), .cpyWe(cpyWe), .cpuClk(cpuClk), .activeCh(activeCh),
    .grantCpu(grantCpu), .grantCpy(grantCpy), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model of one slot, from the requirements
  task automatic predict();
    int c;
    logic [ADDR_W-1:0] a;
    logic cpuWin, cpyWin;
    c      = benchSlot % NUM_CH;
    a      = cpuAddr[c*ADDR_W +: ADDR_W];
    cpuWin = cpuReq[c] && (a >= MAIN_BASE);
    cpyWin = !cpuWin && cpyReq[c];
    expCh  = c;
    expEn  = cpuWin || cpyWin;
    expGC  = cpuWin ? NUM_CH'(1) << c : '0;
    expGY  = cpyWin ? NUM_CH'(1) << c : '0;
    if (cpuWin) begin
      expAddr = a; expData = cpuWData[c*DATA_W +: DATA_W]; expWe = cpuWe[c];
    end else if (cpyWin) begin
      expAddr = cpyAddr[c*ADDR_W +: ADDR_W];
      expData = cpyWData[c*DATA_W +: DATA_W]; expWe = cpyWe[c];
    end else begin
      expAddr = '0; expData = '0; expWe = 1'b0;
    end
    for (int n = 0; n < NUM_CH; n++) begin
      int ph;
      ph = ((c - n) % NUM_CH + NUM_CH) % NUM_CH;
      expClk[n] = (ph < NUM_CH / 2);
    end
    benchSlot++;
  endtask

  task automatic checkSlot();
    chk("R1", "activeCh", 64'(activeCh), 64'(expCh));
    chk("R2/R3/R10", "grantCpu", 64'(grantCpu), 64'(expGC));
    chk("R3/R5/R6", "grantCpy", 64'(grantCpy), 64'(expGY));
    chk("R4", "memEn", 64'(memEn), 64'(expEn));
    chk("R4/R7", "memWe", 64'(memWe), 64'(expWe));
    chk("R6/R7", "memAddr", 64'(memAddr), 64'(expAddr));
    chk("R2/R3", "memWData", 64'(memWData), 64'(expData));
    chk("R8", "cpuClk", 64'(cpuClk), 64'(expClk));
  endtask

  task automatic randomAll();
    for (int n = 0; n < NUM_CH; n++) begin
      if ($urandom_range(1, 0) == 1)
        cpuAddr[n*ADDR_W +: ADDR_W] = ADDR_W'($urandom % 32'(MAIN_BASE));
      else
        cpuAddr[n*ADDR_W +: ADDR_W] = ADDR_W'($urandom);
      cpyAddr[n*ADDR_W +: ADDR_W] = ADDR_W'($urandom);
    end
    cpuWData = NUM_CH*DATA_W'($urandom);
    cpyWData = NUM_CH*DATA_W'($urandom);
    cpuReq = NUM_CH'($urandom); cpuWe = NUM_CH'($urandom);
    cpyReq = NUM_CH'($urandom); cpyWe = NUM_CH'($urandom);
  endtask

  // Drive one slot: inputs at a falling edge, check at the next falling edge
  task automatic runSlot();
    predict();
    @(negedge clk);
    checkSlot();
  endtask

  // Directed pattern on the channel about to be served, others random (R6)
  task automatic directed(int kind);
    int c;
    randomAll();
    c = benchSlot % NUM_CH;
    case (kind)
      0: begin // R2 boundary: exactly MAIN_BASE is main memory
        cpuReq[c] = 1'b1; cpuAddr[c*ADDR_W +: ADDR_W] = MAIN_BASE; cpyReq[c] = 1'b0;
      end
      1: begin // R10: one below MAIN_BASE leaves the slot to the copy engine
        cpuReq[c] = 1'b1; cpuAddr[c*ADDR_W +: ADDR_W] = MAIN_BASE - 1'b1; cpyReq[c] = 1'b1;
      end
      2: begin // R4: nobody on this channel
        cpuReq[c] = 1'b0; cpyReq[c] = 1'b0;
      end
      default: begin // R2 priority: both want main memory
        cpuReq[c] = 1'b1; cpuAddr[c*ADDR_W +: ADDR_W] = 16'hFFFF; cpyReq[c] = 1'b1;
        cpuWe[c] = 1'b1; cpyWe[c] = 1'b0;
      end
    endcase
    runSlot();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: heavy requests during reset must not leak
    cpuReq = '1; cpyReq = '1; cpuWe = '1; cpyWe = '1;
    cpuAddr = '1; cpyAddr = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "activeCh", 64'(activeCh), 64'd0);
    chk("R9", "grants", 64'({grantCpu, grantCpy}), 64'd0);
    chk("R9", "memEn/memWe", 64'({memEn, memWe}), 64'd0);
    chk("R9", "cpuClk", 64'(cpuClk), 64'd0);
    rstN = 1'b1;
    benchSlot = 0;
    // first slots directed, so R1 start order is seen with known traffic
    for (int k = 0; k < 16; k++) directed(k % 4);
    for (int k = 0; k < 2000; k++) begin
      if (k % 7 == 0) directed(int'($urandom_range(3, 0)));
      else begin
        randomAll();
        runSlot();
      end
    end
    // R9 again: reset in mid-run returns to channel 0 with known clocks
    rstN = 1'b0;
    @(negedge clk);
    chk("R9", "activeCh after mid reset", 64'(activeCh), 64'd0);
    chk("R9", "cpuClk after mid reset", 64'(cpuClk), 64'd0);
    rstN = 1'b1;
    benchSlot = 0;
    for (int k = 0; k < 8; k++) directed(k % 4);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule